// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a processor's load/store stage and a 32-bit word-wide, byte-addressed, little-endian data memory. For every request it forms the effective address from a base register value and a signed 12-bit offset. It drives that address to the memory and flags any access that breaks the natural alignment of its size. For stores it steers the low byte, the low halfword or the whole register value into the right byte lanes and raises the matching byte-write enables.

The memory answers a read one clock after the address is presented. The unit keeps the size, signedness and lane of each accepted load for that one cycle. When the word returns, it picks out the requested byte or halfword and sign- or zero-extends it to 32 bits. Misaligned accesses never write memory and never return load data. Trapping on them is left to the surrounding core, which sees the flag.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address on `mem_addr` equals `req_base` plus `req_offset` sign-extended from 12 bits, modulo 2^32, and is driven in the same cycle as the request.
- R2: Lane order is little-endian. The byte at an address whose two low bits are k travels on data bits [8k+7:8k]. The halfword at an address whose bit 1 is h travels on bits [16h+15:16h]. For example, byte stores to addresses 0 to 3 followed by a word load return the bytes with address 0 in the low bits.
- R3: When `req_zext`=0, a byte load (`req_size`=2'b00) fills result bits [31:8] with bit 7 of the selected byte. A halfword load (`req_size`=2'b01) fills bits [31:16] with bit 15 of the selected halfword.
- R4: When `req_zext`=1, byte and halfword loads fill the upper result bits with zeros. For word accesses (`req_size`=2'b10, and 2'b11, which is treated as word), `req_zext` has no effect.
- R5: An aligned byte store drives `mem_be` = 4'b0001 shifted left by the two low address bits. It drives `mem_wdata` = the low 8 bits of `req_wvalue` copied into all four lanes. Bits [31:8] of `req_wvalue` have no effect.
- R6: An aligned halfword store drives `mem_be` = 4'b0011 (address bit 1 = 0) or 4'b1100 (bit 1 = 1). It drives `mem_wdata` = the low 16 bits of `req_wvalue` in both halves. Bits [31:16] have no effect.
- R7: An aligned word store drives `mem_be` = 4'b1111 and `mem_wdata` = `req_wvalue`.
- R8: `misaligned` is 1 for a valid halfword access at an odd address, and for a valid word access whose two low address bits are not 00. A misaligned store drives `mem_be` = 0 and leaves memory unchanged.
- R9: An aligned load accepted in cycle n raises `load_valid` for exactly cycle n+1, with the extended value on `load_data`. Stores, misaligned loads and idle cycles give `load_valid` = 0 and `load_data` = 0 in the next cycle.
- R10: `mem_be` is 0 whenever `req_valid` is 0 or the request is a load. During reset `load_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 treated as word |
| req_zext | input | 1 | Load extension: 1 zero-extend, 0 sign-extend |
| req_base | input | 32 | Base register value |
| req_offset | input | 12 | Signed address offset |
| req_wvalue | input | 32 | Register value to store |
| mem_rdata | input | 32 | Word read from memory, one cycle after the address |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Byte-write enables, bit k for lane k |
| mem_wdata | output | 32 | Lane-steered store data |
| misaligned | output | 1 | Request breaks natural alignment |
| load_valid | output | 1 | Load result present this cycle |
| load_data | output | 32 | Extended load result |

## Verification
The bench first writes the word 0x00000180, then reads back its bytes signed and unsigned. This shows whether sign extension comes from the selected byte or from another one (0x01 against 0xFFFFFF80). A store of 0xABCDEF80 at offset 2 must leave 0x00800180, which tells lane steering apart from storing the whole register. Halfword values with bit 15 set are loaded from both halves in both signedness modes, so a swapped half or a missing extension path shows up. It also runs a sweep of byte stores over every lane, negative offsets, a base that is itself unaligned, and misaligned halfword and word accesses. The sweep separates address arithmetic, lane order and the suppression of writes and load results.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic             valid;
        acc_size_e        size;
        logic             zext;
        logic [LANE_W-1:0] lane;
    } pend_load_t;

    function automatic logic breaks_alignment(acc_size_e sz, logic [LANE_W-1:0] lo);
        case (sz)
            SZ_BYTE: return 1'b0;
            SZ_HALF: return lo[0];
            default: return |lo;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lanes_touched(acc_size_e sz, logic [LANE_W-1:0] lo);
        case (sz)
            SZ_BYTE: return LANES'(1) << lo;
            SZ_HALF: return lo[1] ? 4'b1100 : 4'b0011;
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  acc_size_e         size,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              bad_align
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;

    assign off_ext   = {{EXT_W{offset[OFF_W-1]}}, offset};
    assign eff_addr  = base + off_ext;
    assign bad_align = breaks_alignment(size, eff_addr[LANE_W-1:0]);

endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
    import lsu_lane_pkg::*;
(
    input  logic              wr_en,
    input  acc_size_e         size,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] value,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);
    logic [LANES-1:0] touched;

    assign touched = lanes_touched(size, lane);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign be[i] = wr_en & touched[i];
        always_comb begin
            case (size)
                SZ_BYTE: wdata[8*i +: 8] = value[7:0];
                SZ_HALF: wdata[8*i +: 8] = value[8*(i%2) +: 8];
                default: wdata[8*i +: 8] = value[8*i +: 8];
            endcase
        end
    end

    always_comb begin
        if (size == SZ_HALF)
            assert_half_pair_R6: assert (be == 4'b0000 || be == 4'b0011 || be == 4'b1100);
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pend_load_t        pend,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] data
);
    logic [7:0]  lane_byte [LANES];
    logic [7:0]  sel_b;
    logic [15:0] sel_h;
    logic        fill_b;
    logic        fill_h;

    for (genvar i = 0; i < LANES; i++) begin : g_split
        assign lane_byte[i] = rdata[8*i +: 8];
    end

    assign sel_b  = lane_byte[pend.lane];
    assign sel_h  = pend.lane[1] ? rdata[31:16] : rdata[15:0];
    assign fill_b = ~pend.zext & sel_b[7];
    assign fill_h = ~pend.zext & sel_h[15];

    always_comb begin
        if (!pend.valid) begin
            data = '0;
        end else begin
            case (pend.size)
                SZ_BYTE: data = {{(DATA_W-8){fill_b}}, sel_b};
                SZ_HALF: data = {{(DATA_W-16){fill_h}}, sel_h};
                default: data = rdata;
            endcase
        end
    end

    assert_sext_byte_R3: assert property (@(posedge clk) disable iff (rst)
        (pend.valid && pend.size == SZ_BYTE && !pend.zext)
            |-> (data[31:8] == {24{rdata[8*pend.lane + 7]}}));

    assert_zext_half_R4: assert property (@(posedge clk) disable iff (rst)
        (pend.valid && pend.size == SZ_HALF && pend.zext) |-> (data[31:16] == 16'h0));

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_zext,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [31:0]       req_wvalue,
    input  logic [31:0]       mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    output logic              misaligned,
    output logic              load_valid,
    output logic [31:0]       load_data
);
    acc_size_e  size;
    logic       bad_align;
    logic       wr_en;
    pend_load_t pend_q;

    assign size = acc_size_e'(req_size);

    lsu_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
        .base      (req_base),
        .offset    (req_offset),
        .size      (size),
        .eff_addr  (mem_addr),
        .bad_align (bad_align)
    );

    assign misaligned = req_valid & bad_align;
    assign wr_en      = req_valid & req_store & ~bad_align;

    lsu_store_steer u_store (
        .wr_en (wr_en),
        .size  (size),
        .lane  (mem_addr[LANE_W-1:0]),
        .value (req_wvalue),
        .be    (mem_be),
        .wdata (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q.valid <= req_valid & ~req_store & ~bad_align;
            pend_q.size  <= size;
            pend_q.zext  <= req_zext;
            pend_q.lane  <= mem_addr[LANE_W-1:0];
        end
    end

    lsu_load_extract u_load (
        .clk   (clk),
        .rst   (rst),
        .pend  (pend_q),
        .rdata (mem_rdata),
        .data  (load_data)
    );

    assign load_valid = pend_q.valid;

    assert_be_quiet_misalign_R8: assert property (@(posedge clk) disable iff (rst)
        misaligned |-> (mem_be == 4'b0000));

    assert_be_quiet_load_R10: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || !req_store) |-> (mem_be == 4'b0000));

    assert_be_shape_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_be == 4'b0000 || $countones(mem_be) == 1 ||
         $countones(mem_be) == 2 || mem_be == 4'b1111));

    assert_load_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_store && !misaligned) |=> load_valid);

    assert_store_no_load_R9: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || req_store || misaligned) |=> !load_valid);

endmodule

// File: tb/lsu_lane_unit_test.sv
`timescale 1ns/1ps
module lsu_lane_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_store = 1'b0, req_zext = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_base = '0, req_wvalue = '0;
    logic [11:0] req_offset = '0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem_addr, mem_wdata, load_data;
    logic [3:0]  mem_be;
    logic        misaligned, load_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lsu_lane_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_zext(req_zext), .req_base(req_base),
        .req_offset(req_offset), .req_wvalue(req_wvalue), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .misaligned(misaligned), .load_valid(load_valid), .load_data(load_data)
    );

    // Behavioural memory driven by the unit's outputs
    logic [7:0] mem [64];
    // Independent reference image updated from the requirements
    logic [7:0] refm [64];

    always @(posedge clk) begin
        logic [5:0] a;
        a = {mem_addr[5:2], 2'b00};
        mem_rdata <= {mem[a+3], mem[a+2], mem[a+1], mem[a]};
        for (int k = 0; k < 4; k++)
            if (mem_be[k]) mem[a+k] = mem_wdata[8*k +: 8];
    end

    logic        exp_lv = 1'b0;
    logic [31:0] exp_ld = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input bit v, input bit st, input logic [1:0] sz, input bit zx,
                        input logic [31:0] base, input logic [11:0] off, input logic [31:0] val);
        logic [31:0] ea, e_wd, e_ld;
        logic [3:0]  e_be;
        bit          e_mis, wordsz;
        int          lo;
        req_valid = v; req_store = st; req_size = sz; req_zext = zx;
        req_base = base; req_offset = off; req_wvalue = val;
        ea = base + {{20{off[11]}}, off};
        lo = int'(ea[1:0]);
        wordsz = sz[1];
        e_mis = v && ((sz == 2'b01 && ea[0]) || (wordsz && ea[1:0] != 2'b00));
        e_be = 4'b0000;
        if (v && st && !e_mis) begin
            if (sz == 2'b00) e_be = 4'b0001 << lo;
            else if (sz == 2'b01) e_be = (lo == 2) ? 4'b1100 : 4'b0011;
            else e_be = 4'b1111;
        end
        if (sz == 2'b00) e_wd = {4{val[7:0]}};
        else if (sz == 2'b01) e_wd = {2{val[15:0]}};
        else e_wd = val;
        @(negedge clk);
        chk(mem_addr == ea, "R1 address", mem_addr, ea);
        chk(misaligned == e_mis, "R8 misaligned flag", {31'b0, misaligned}, {31'b0, e_mis});
        if (!v || !st)
            chk(mem_be == e_be, "R10 enables idle/load", {28'b0, mem_be}, {28'b0, e_be});
        else if (e_mis)
            chk(mem_be == e_be, "R8 enables misaligned", {28'b0, mem_be}, {28'b0, e_be});
        else if (sz == 2'b00)
            chk(mem_be == e_be && mem_wdata == e_wd, "R5 byte store lanes", {mem_be, mem_wdata[27:0]}, {e_be, e_wd[27:0]});
        else if (sz == 2'b01)
            chk(mem_be == e_be && mem_wdata == e_wd, "R6 half store lanes", {mem_be, mem_wdata[27:0]}, {e_be, e_wd[27:0]});
        else
            chk(mem_be == e_be && mem_wdata == e_wd, "R7 word store lanes", {mem_be, mem_wdata[27:0]}, {e_be, e_wd[27:0]});
        if (v && st) chk(mem_wdata == e_wd, "R5 R6 R7 store data", mem_wdata, e_wd);
        chk(load_valid == exp_lv, "R9 load valid", {31'b0, load_valid}, {31'b0, exp_lv});
        chk(load_data == exp_ld, "R2 R3 R4 R9 load data", load_data, exp_ld);
        // reference for the next cycle, from the image before this cycle's write
        exp_lv = v && !st && !e_mis;
        e_ld = '0;
        if (exp_lv) begin
            if (sz == 2'b00)
                e_ld = zx ? {24'h0, refm[ea[5:0]]} : {{24{refm[ea[5:0]][7]}}, refm[ea[5:0]]};
            else if (sz == 2'b01)
                e_ld = zx ? {16'h0, refm[ea[5:0]+1], refm[ea[5:0]]}
                          : {{16{refm[ea[5:0]+1][7]}}, refm[ea[5:0]+1], refm[ea[5:0]]};
            else
                e_ld = {refm[ea[5:0]+3], refm[ea[5:0]+2], refm[ea[5:0]+1], refm[ea[5:0]]};
        end
        exp_ld = e_ld;
        if (v && st && !e_mis) begin
            if (sz == 2'b00) refm[ea[5:0]] = val[7:0];
            else if (sz == 2'b01) begin refm[ea[5:0]] = val[7:0]; refm[ea[5:0]+1] = val[15:8]; end
            else for (int k = 0; k < 4; k++) refm[ea[5:0]+k] = val[8*k +: 8];
        end
        @(posedge clk); #1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin mem[i] = 8'h00; refm[i] = 8'h00; end
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        chk(load_valid == 1'b0 && load_data == 32'h0, "R10 reset load state", {31'b0, load_valid}, 32'h0);
        chk(mem_be == 4'b0, "R10 reset enables", {28'b0, mem_be}, 32'h0);
        @(posedge clk); #1;
        rst = 1'b0;
        step(0, 0, 2'b00, 0, 32'h0, 12'h0, 32'h0);
        // word 0x00000180 and its bytes (R3 R4 R7)
        step(1, 1, 2'b10, 0, 32'h100, 12'h000, 32'h00000180);
        step(1, 0, 2'b00, 0, 32'h100, 12'h001, 32'h0);
        step(1, 0, 2'b00, 0, 32'h100, 12'h000, 32'h0);
        step(1, 0, 2'b00, 1, 32'h100, 12'h000, 32'h0);
        // byte store at lane 2, upper register bits ignored (R5 R2)
        step(1, 1, 2'b00, 0, 32'h100, 12'h002, 32'hABCDEF80);
        step(1, 0, 2'b10, 0, 32'h100, 12'h000, 32'h0);
        // negative offset (R1)
        step(1, 0, 2'b10, 0, 32'h110, 12'hFF0, 32'h0);
        // halfword stores and loads in both halves (R6 R3 R4)
        step(1, 1, 2'b01, 0, 32'h104, 12'h002, 32'h1234F00D);
        step(1, 1, 2'b01, 0, 32'h101, 12'h003, 32'h55558123);
        step(1, 0, 2'b01, 0, 32'h106, 12'h000, 32'h0);
        step(1, 0, 2'b01, 1, 32'h106, 12'h000, 32'h0);
        step(1, 0, 2'b01, 0, 32'h104, 12'h000, 32'h0);
        step(1, 0, 2'b01, 1, 32'h104, 12'h000, 32'h0);
        // word loads ignore the extension flag, size 11 acts as word (R4)
        step(1, 0, 2'b10, 1, 32'h104, 12'h000, 32'h0);
        step(1, 0, 2'b11, 0, 32'h104, 12'h000, 32'h0);
        // byte sweep over all lanes then word read back (R2 R5)
        for (int k = 0; k < 4; k++)
            step(1, 1, 2'b00, 0, 32'h108, 12'(k), 32'hFFFFFF00 | (32'h11 * (k + 1)));
        step(1, 0, 2'b10, 0, 32'h108, 12'h000, 32'h0);
        for (int k = 0; k < 4; k++)
            step(1, 0, 2'b00, 0, 32'h108, 12'(k), 32'h0);
        // misaligned accesses (R8 R9)
        step(1, 1, 2'b01, 0, 32'h108, 12'h001, 32'hDEADBEEF);
        step(1, 1, 2'b10, 0, 32'h108, 12'h002, 32'hDEADBEEF);
        step(1, 1, 2'b11, 0, 32'h108, 12'h003, 32'hDEADBEEF);
        step(1, 0, 2'b10, 0, 32'h108, 12'h001, 32'h0);
        step(1, 0, 2'b01, 0, 32'h108, 12'h003, 32'h0);
        step(1, 0, 2'b10, 0, 32'h108, 12'h000, 32'h0);
        // a store right after a load, then idle (R9 R10)
        step(1, 1, 2'b10, 0, 32'h10C, 12'h000, 32'h8001FF7F);
        step(0, 1, 2'b10, 0, 32'h10C, 12'h000, 32'hFFFFFFFF);
        step(1, 0, 2'b00, 0, 32'h10C, 12'h000, 32'h0);
        step(1, 0, 2'b01, 0, 32'h10C, 12'h002, 32'h0);
        step(0, 0, 2'b00, 0, 32'h0, 12'h0, 32'h0);
        step(0, 0, 2'b00, 0, 32'h0, 12'h0, 32'h0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule